// File: doc/BRIEF.md
# BCD Calendar Counter with Century Flag

This block keeps wall-clock time and calendar date as packed BCD values: seconds, minutes, hours, day of week, day of month, month and two-digit year. Each one-cycle pulse on `tick` moves the time forward by one second. A carry passes up the chain, and the date wraps at the length of the current month, with leap years counted. The one-second pulse comes from outside the block.

Software reaches eight byte-wide registers through a simple address/data port. A write commits on the next clock edge. The read data is combinational from the address. Two bits of the hours register control the century: an enable bit and the century flag. When the enable is set, the flag inverts each time the year wraps. A stop bit at the top of the seconds register freezes timekeeping while the registers stay writable.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the registers read, by address 0 to 7: 00, 00, 00, 01, 01, 01, 00, 00 (seconds, minutes, century/hours, day of week, date, month, year, control).
- R2: Seconds and minutes count 00 to 59 and wrap to 00 with a carry to the next field. Hours count 00 to 23 in bits 5:0 of address 2. All of them step in packed BCD, with the tens digit in the upper nibble.
- R3: While bit 7 of address 0 (the stop bit) is 1, a tick changes no time field. It reads back along with the seconds.
- R4: The date wraps to 01 after the last day of its month, carrying into the month: after 30 for months 04, 06, 09 and 11, after 31 for the other non-February months.
- R5: February ends after 29 when the BCD year is a multiple of four, and after 28 otherwise.
- R6: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R7: When address 2 bit 7 (century enable) is 1, address 2 bit 6 (the century flag) inverts when the year wraps from 99 to 00.
- R8: When the century enable is 0, the century flag keeps its value through a year wrap.
- R9: At each midnight the day of week advances and wraps from 07 to 01, independently of the date value.
- R10: Unused bits read as zero and ignore writes: minutes bit 7, day-of-week bits 7:3, date bits 7:6 and month bits 7:5.
- R11: A write to any of addresses 0 to 6 takes effect on the next clock and discards a tick in the same cycle. No time field advances on that tick.
- R12: Address 7 is an 8-bit register that stores whatever is written to it. A write to it does not discard a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |

## Verification
A software write and a one-second tick can arrive in the same cycle. The bench provokes this by raising `wr_en` and `tick` on the same clock edge. After a write to a time register, the written field must hold the new value and the seconds must not have moved. After a write to the control register, the seconds must have advanced and the control value must also be stored. The other collision is a full carry ripple, from second through year and century flag, within a single tick. It is judged by reading every register after that one edge.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 8;

  typedef logic [DATA_W-1:0] bcd_t;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int A_CTRL = 7;

  // Next packed-BCD value, no range check.
  function automatic bcd_t bcd_inc(input bcd_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Divisible by four: (10*t + u) mod 4 == (2*t + u) mod 4.
  function automatic logic bcd_leap(input bcd_t yr);
    logic [1:0] s;
    s = yr[1:0] + {yr[4], 1'b0};
    return (s == 2'd0);
  endfunction

  function automatic bcd_t bcd_month_len(input bcd_t mon, input bcd_t yr);
    case (mon)
      8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic bcd_t field_low(input int i);
    return (i == F_DOW || i == F_DATE || i == F_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic bcd_t field_mask(input int i);
    case (i)
      F_SEC, F_MIN: return 8'h7F;
      F_HOUR:       return 8'h3F;
      F_DOW:        return 8'h07;
      F_DATE:       return 8'h3F;
      F_MON:        return 8'h1F;
      default:      return 8'hFF;
    endcase
  endfunction

  function automatic bcd_t field_top(input int i);
    case (i)
      F_SEC, F_MIN: return 8'h59;
      F_HOUR:       return 8'h23;
      F_DOW:        return 8'h07;
      F_MON:        return 8'h12;
      default:      return 8'h99;
    endcase
  endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_cal_pkg::*;
#(
  parameter bcd_t LOW  = 8'h00,
  parameter bcd_t MASK = 8'hFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  bcd_t limit,
  input  logic load,
  input  bcd_t load_val,
  output bcd_t value,
  output logic at_limit
);
  bcd_t q;

  assign at_limit = (q >= limit);
  assign value    = q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= LOW;
    else if (load) q <= load_val & MASK;
    else if (en)   q <= at_limit ? LOW : (bcd_inc(q) & MASK);
  end
endmodule

// File: rtl/rtc_century.sv
module rtc_century (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic ceb_in,
  input  logic cb_in,
  input  logic year_wrap,
  output logic ceb,
  output logic cb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ceb <= 1'b0;
      cb  <= 1'b0;
    end else if (load) begin
      ceb <= ceb_in;
      cb  <= cb_in;
    end else if (year_wrap && ceb) begin
      cb  <= ~cb;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  bcd_t                  fld_q   [NUM_FIELDS];
  bcd_t                  fld_lim [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] fld_at;
  logic [NUM_FIELDS-1:0] fld_en;
  logic [NUM_FIELDS-1:0] fld_ld;

  logic stop_q, ceb_q, cb_q;
  bcd_t ctrl_q;

  // Named internal events
  logic time_write, adv;
  logic sec_wrap, min_wrap, hr_wrap, date_wrap, mon_wrap, yr_wrap;
  bcd_t month_len;

  assign time_write = wr_en && (addr != 3'(A_CTRL));
  assign adv        = tick && !stop_q && !time_write;

  assign month_len  = bcd_month_len(fld_q[F_MON], fld_q[F_YEAR]);

  assign sec_wrap   = adv       && fld_at[F_SEC];
  assign min_wrap   = sec_wrap  && fld_at[F_MIN];
  assign hr_wrap    = min_wrap  && fld_at[F_HOUR];
  assign date_wrap  = hr_wrap   && fld_at[F_DATE];
  assign mon_wrap   = date_wrap && fld_at[F_MON];
  assign yr_wrap    = mon_wrap  && fld_at[F_YEAR];

  assign fld_en = {mon_wrap, date_wrap, hr_wrap, hr_wrap, min_wrap, sec_wrap, adv};

  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) begin
      fld_lim[i] = (i == F_DATE) ? month_len : field_top(i);
      fld_ld[i]  = wr_en && (addr == 3'(i));
    end
  end

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    rtc_bcd_field #(
      .LOW  (field_low(gi)),
      .MASK (field_mask(gi))
    ) u_field (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (fld_en[gi]),
      .limit    (fld_lim[gi]),
      .load     (fld_ld[gi]),
      .load_val (wdata),
      .value    (fld_q[gi]),
      .at_limit (fld_at[gi])
    );
  end

  rtc_century u_century (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fld_ld[F_HOUR]),
    .ceb_in    (wdata[7]),
    .cb_in     (wdata[6]),
    .year_wrap (yr_wrap),
    .ceb       (ceb_q),
    .cb        (cb_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      ctrl_q <= '0;
    end else begin
      if (fld_ld[F_SEC]) stop_q <= wdata[7];
      if (wr_en && addr == 3'(A_CTRL)) ctrl_q <= wdata;
    end
  end

  always_comb begin
    case (addr)
      3'(F_SEC):  rdata = {stop_q, fld_q[F_SEC][6:0]};
      3'(F_HOUR): rdata = {ceb_q, cb_q, fld_q[F_HOUR][5:0]};
      3'(A_CTRL): rdata = ctrl_q;
      default:    rdata = fld_q[addr];
    endcase
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic       stop_q,
  input logic       ceb_q,
  input logic       cb_q,
  input logic [7:0] sec_q,
  input logic [7:0] dow_q,
  input logic       adv,
  input logic       sec_wrap,
  input logic       hr_wrap,
  input logic       yr_wrap,
  input logic       time_write
);
  a_r2_sec_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_wrap && !wr_en) |=> (sec_q == 8'h00));

  a_r3_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !wr_en) |=> $stable(sec_q));

  a_r3_no_adv_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> !adv);

  a_r7_century_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (yr_wrap && ceb_q && !(wr_en && addr == 3'd2)) |=> (cb_q != $past(cb_q)));

  a_r8_century_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!ceb_q && !(wr_en && addr == 3'd2)) |=> $stable(cb_q));

  a_r9_dow_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_wrap && dow_q == 8'h07 && !wr_en) |=> (dow_q == 8'h01));

  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0) |=> (sec_q == ($past(wdata) & 8'h7F)));

  a_r11_no_adv_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    time_write |-> !adv);
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .stop_q     (stop_q),
  .ceb_q      (ceb_q),
  .cb_q       (cb_q),
  .sec_q      (fld_q[0]),
  .dow_q      (fld_q[3]),
  .adv        (adv),
  .sec_wrap   (sec_wrap),
  .hr_wrap    (hr_wrap),
  .yr_wrap    (yr_wrap),
  .time_write (time_write)
);

// File: tb/test_rtc_calendar.sv
`timescale 1ns/1ps
module test_rtc_calendar;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  rtc_calendar i_rtc_calendar (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic one_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    total++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, rdata, exp);
    end
  endtask

  // Hour byte carries the century bits as written.
  task automatic set_time(input logic [7:0] yr, mo, dt, dw, hr, mi, se);
    wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, dt); wr(3'd3, dw);
    wr(3'd2, hr); wr(3'd1, mi); wr(3'd0, se);
  endtask

  task automatic t_reset();
    expect_reg(3'd0, 8'h00, "R1"); expect_reg(3'd1, 8'h00, "R1");
    expect_reg(3'd2, 8'h00, "R1"); expect_reg(3'd3, 8'h01, "R1");
    expect_reg(3'd4, 8'h01, "R1"); expect_reg(3'd5, 8'h01, "R1");
    expect_reg(3'd6, 8'h00, "R1"); expect_reg(3'd7, 8'h00, "R1");
  endtask

  task automatic t_minute_carry();
    set_time(8'h21, 8'h03, 8'h10, 8'h02, 8'h08, 8'h05, 8'h59);
    one_tick();
    expect_reg(3'd0, 8'h00, "R2"); expect_reg(3'd1, 8'h06, "R2");
    expect_reg(3'd2, 8'h08, "R2");
    set_time(8'h21, 8'h03, 8'h10, 8'h02, 8'h09, 8'h59, 8'h59);
    one_tick();
    expect_reg(3'd1, 8'h00, "R2"); expect_reg(3'd2, 8'h10, "R2");
  endtask

  task automatic t_full_ripple_ceb();
    set_time(8'h99, 8'h12, 8'h31, 8'h07, 8'hA3, 8'h59, 8'h59);
    one_tick();
    expect_reg(3'd0, 8'h00, "R2"); expect_reg(3'd1, 8'h00, "R2");
    expect_reg(3'd2, 8'hC0, "R7"); expect_reg(3'd3, 8'h01, "R9");
    expect_reg(3'd4, 8'h01, "R4"); expect_reg(3'd5, 8'h01, "R6");
    expect_reg(3'd6, 8'h00, "R6");
  endtask

  task automatic t_century_off();
    set_time(8'h99, 8'h12, 8'h31, 8'h04, 8'h63, 8'h59, 8'h59);
    one_tick();
    expect_reg(3'd2, 8'h40, "R8"); expect_reg(3'd6, 8'h00, "R8");
  endtask

  task automatic month_end(input logic [7:0] yr, mo, dt, exp_mo, exp_dt, input string req);
    set_time(yr, mo, dt, 8'h01, 8'h23, 8'h59, 8'h59);
    one_tick();
    expect_reg(3'd5, exp_mo, req); expect_reg(3'd4, exp_dt, req);
  endtask

  task automatic t_month_lengths();
    month_end(8'h21, 8'h04, 8'h30, 8'h05, 8'h01, "R4");
    month_end(8'h21, 8'h05, 8'h30, 8'h05, 8'h31, "R4");
    month_end(8'h21, 8'h11, 8'h30, 8'h12, 8'h01, "R4");
    month_end(8'h23, 8'h02, 8'h28, 8'h03, 8'h01, "R5");
    month_end(8'h24, 8'h02, 8'h28, 8'h02, 8'h29, "R5");
    month_end(8'h24, 8'h02, 8'h29, 8'h03, 8'h01, "R5");
    month_end(8'h12, 8'h02, 8'h28, 8'h02, 8'h29, "R5");
    month_end(8'h10, 8'h02, 8'h28, 8'h03, 8'h01, "R5");
  endtask

  task automatic t_dow_independent();
    set_time(8'h22, 8'h06, 8'h15, 8'h03, 8'h23, 8'h59, 8'h59);
    one_tick();
    expect_reg(3'd3, 8'h04, "R9"); expect_reg(3'd4, 8'h16, "R9");
  endtask

  task automatic t_stop();
    wr(3'd0, 8'h85);
    one_tick(); one_tick();
    expect_reg(3'd0, 8'h85, "R3");
    wr(3'd0, 8'h05);
    one_tick();
    expect_reg(3'd0, 8'h06, "R3");
  endtask

  task automatic t_collision();
    wr(3'd0, 8'h10);
    @(negedge clk);
    wr_en = 1'b1; tick = 1'b1; addr = 3'd1; wdata = 8'h22;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    expect_reg(3'd1, 8'h22, "R11"); expect_reg(3'd0, 8'h10, "R11");
    @(negedge clk);
    wr_en = 1'b1; tick = 1'b1; addr = 3'd7; wdata = 8'h5A;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    expect_reg(3'd0, 8'h11, "R12"); expect_reg(3'd7, 8'h5A, "R12");
  endtask

  task automatic t_unused_bits();
    wr(3'd1, 8'hFF); expect_reg(3'd1, 8'h7F, "R10");
    wr(3'd3, 8'hFF); expect_reg(3'd3, 8'h07, "R10");
    wr(3'd4, 8'hFF); expect_reg(3'd4, 8'h3F, "R10");
    wr(3'd5, 8'hFF); expect_reg(3'd5, 8'h1F, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_minute_carry();
    t_full_ripple_ceb();
    t_century_off();
    t_month_lengths();
    t_dow_independent();
    t_stop();
    t_collision();
    t_unused_bits();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule